// File: doc/BRIEF.md
# GF(2^8) P/Q Parity Accumulator

This block computes two parity bytes, P and Q, over a group of equal-length source buffers. It works one byte position at a time. For each position the sources arrive as a stream of beats, and each beat carries a source index and one data byte. Every source has a programmable pair of coefficients, one for P and one for Q. The block multiplies each byte by its coefficients in GF(2^8) and XORs the products into two running accumulators. When the beat with the last index of the group arrives, the block presents the finished P and Q bytes for that position.

An operation starts with a start strobe that carries three things: the number of data sources (encoded as count minus one), a continuation flag and a transfer length in bytes. When the continuation flag is set, the stream for each position carries three more beats after the data sources. These beats hold the previous P, the previous Q and the previous Q again. The block weights them with fixed coefficients, so the new parity extends the old one. The operation ends after the given number of positions. A start with bad parameters is refused with a one-cycle reject pulse.

Top module: `pq_parity_acc`

## Requirements
- R1: out_p is the XOR, over the sources of a position, of the P coefficient of each source multiplied in GF(2^8) by its byte. With P coefficients of 1 this reduces to a plain XOR.
- R2: out_q is the XOR, over the sources, of the Q coefficient multiplied by the byte in GF(2^8). The field uses the reduction polynomial x^8+x^4+x^3+x^2+1 (low byte 0x1D), so 0x80 times 0x02 gives 0x1D.
- R3: op_srcs_m1 holds the number of data sources minus one. Data source i is the beat with in_idx = i and uses coefficient slot i. A position completes on the beat whose index is op_srcs_m1 (without continuation).
- R4: With op_cont = 1, indices N, N+1 and N+2 (N = op_srcs_m1+1) carry old P, old Q and old Q. Their coefficients are fixed at P = 1, 1, 1 and Q = 0, 0, 1, whatever the slot registers contain. The position completes at index N+2.
- R5: op_srcs_m1 = 0 (a single source) is refused. A single-source Q is formed by sending the source twice, with the second Q coefficient set to 0.
- R6: out_valid pulses for exactly one cycle, in the cycle after the clock edge that takes the position's last beat. out_p and out_q keep their value until the next result.
- R7: A beat with index 0 restarts both accumulators, so nothing sent earlier for that position affects the result.
- R8: A beat is ignored when no operation is running, or when its index is above the position's last index. Such a beat produces no output and does not change the result.
- R9: A start is refused (op_reject pulses one cycle later and op_busy stays 0) when the length is 0 or above MAX_LEN (1 MiB), or when R5 applies. A length of exactly MAX_LEN is accepted.
- R10: op_busy rises the cycle after an accepted start. It falls together with the out_valid of the final position, which has out_last = 1. op_start is ignored while op_busy is 1.
- R11: After reset, op_busy, op_reject, out_valid, out_p, out_q and out_last are 0, and every coefficient slot holds P = 1, Q = 1.
- R12: cfg_we writes cfg_pcoef and cfg_qcoef into slot cfg_slot. The write takes effect for beats taken from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Coefficient slot write strobe |
| cfg_slot | input | 4 | Slot written |
| cfg_pcoef | input | 8 | P coefficient to write |
| cfg_qcoef | input | 8 | Q coefficient to write |
| op_start | input | 1 | Start an operation |
| op_srcs_m1 | input | 4 | Data source count minus one |
| op_cont | input | 1 | Fold previous P/Q back in as three extra sources |
| op_len | input | 21 | Number of byte positions |
| op_busy | output | 1 | Operation in progress |
| op_reject | output | 1 | One-cycle pulse for a refused start |
| in_valid | input | 1 | Source beat valid |
| in_idx | input | 5 | Source index of the beat |
| in_byte | input | 8 | Source data byte |
| out_valid | output | 1 | Result pulse for one position |
| out_p | output | 8 | P parity byte |
| out_q | output | 8 | Q parity byte |
| out_last | output | 1 | Result belongs to the final position |

## Verification
The bench multiplies a lone 0x80 by 0x02. A multiplier that reduced with the wrong polynomial, or did not reduce, would return something other than 0x1D. In the continuation test, the slot registers behind indices 3 to 5 hold nonzero junk. A design that read those slots instead of the fixed continuation coefficients would corrupt Q, and a design that dropped the third beat would emit its result early. The bench also sends a repeated index 0 and an out-of-range index in the middle of a position; a design that did not restart, or that accumulated foreign beats, would give a wrong byte. Lengths of 0, MAX_LEN+1 and MAX_LEN probe the limit check, where an off-by-one either refuses the largest legal transfer or starts an illegal one.

// File: rtl/pq_acc_pkg.sv
package pq_acc_pkg;

    typedef logic [7:0] gf_t;

    // Low byte of the field polynomial x^8+x^4+x^3+x^2+1
    localparam gf_t GF_POLY = 8'h1D;

    typedef struct packed {
        gf_t p;
        gf_t q;
    } coef_pair_t;

    localparam coef_pair_t COEF_UNITY = '{p: 8'h01, q: 8'h01};

endpackage

// File: rtl/pq_gf_mul.sv
module pq_gf_mul
    import pq_acc_pkg::*;
(
    input  gf_t a,
    input  gf_t b,
    output gf_t y
);

    // pw[i] = a * x^i reduced; part[i] = sum of selected pw below bit i
    gf_t pw   [8];
    gf_t part [9];

    assign pw[0]   = a;
    assign part[0] = '0;

    genvar i;
    generate
        for (i = 0; i < 7; i++) begin : g_pow
            assign pw[i+1] = {pw[i][6:0], 1'b0} ^ (pw[i][7] ? GF_POLY : 8'h00);
        end
        for (i = 0; i < 8; i++) begin : g_sum
            assign part[i+1] = part[i] ^ (b[i] ? pw[i] : 8'h00);
        end
    endgenerate

    assign y = part[8];

endmodule

// File: rtl/pq_coef_bank.sv
module pq_coef_bank
    import pq_acc_pkg::*;
#(
    parameter int NUM_DATA = 16,
    parameter int SLOT_W   = 4,
    parameter int IDX_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  coef_pair_t        wr_pair,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [IDX_W-1:0]  data_last,
    input  logic [IDX_W-1:0]  cont_last,
    output coef_pair_t        rd_pair
);

    coef_pair_t slot_q [NUM_DATA];
    coef_pair_t slot_d [NUM_DATA];

    always_comb begin
        for (int s = 0; s < NUM_DATA; s++) begin
            slot_d[s] = slot_q[s];
        end
        if (wr_en && (32'(wr_slot) < NUM_DATA)) begin
            slot_d[wr_slot] = wr_pair;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_DATA; s++) begin
                slot_q[s] <= COEF_UNITY;
            end
        end else begin
            for (int s = 0; s < NUM_DATA; s++) begin
                slot_q[s] <= slot_d[s];
            end
        end
    end

    // Data indices read the slots; the folded-back beats use fixed weights
    always_comb begin
        if (rd_idx <= data_last) begin
            rd_pair = slot_q[rd_idx[SLOT_W-1:0]];
        end else begin
            rd_pair.p = 8'h01;
            rd_pair.q = (rd_idx == cont_last) ? 8'h01 : 8'h00;
        end
    end

endmodule

// File: rtl/pq_parity_acc.sv
module pq_parity_acc
    import pq_acc_pkg::*;
#(
    parameter int NUM_DATA = 16,
    parameter int MAX_LEN  = 1048576,
    localparam int NUM_CONT = 3,
    localparam int NUM_IDX  = NUM_DATA + NUM_CONT,
    localparam int SLOT_W   = $clog2(NUM_DATA),
    localparam int IDX_W    = $clog2(NUM_IDX),
    localparam int LEN_W    = $clog2(MAX_LEN) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [7:0]        cfg_pcoef,
    input  logic [7:0]        cfg_qcoef,
    input  logic              op_start,
    input  logic [SLOT_W-1:0] op_srcs_m1,
    input  logic              op_cont,
    input  logic [LEN_W-1:0]  op_len,
    output logic              op_busy,
    output logic              op_reject,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [7:0]        in_byte,
    output logic              out_valid,
    output logic [7:0]        out_p,
    output logic [7:0]        out_q,
    output logic              out_last
);

    localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_LEN);
    localparam logic [IDX_W-1:0] CONT_EXTRA = IDX_W'(NUM_CONT);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] data_last;
        logic [IDX_W-1:0] beat_last;
        logic [LEN_W-1:0] pos_left;
        gf_t              acc_p;
        gf_t              acc_q;
        logic             reject;
        logic             res_valid;
        gf_t              res_p;
        gf_t              res_q;
        logic             res_last;
    } state_t;

    state_t     s_q, s_d;
    coef_pair_t coef;
    gf_t        term_p, term_q;

    pq_coef_bank #(
        .NUM_DATA (NUM_DATA),
        .SLOT_W   (SLOT_W),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_slot   (cfg_slot),
        .wr_pair   ('{p: cfg_pcoef, q: cfg_qcoef}),
        .rd_idx    (in_idx),
        .data_last (s_q.data_last),
        .cont_last (s_q.beat_last),
        .rd_pair   (coef)
    );

    pq_gf_mul u_mul_p (.a(in_byte), .b(coef.p), .y(term_p));
    pq_gf_mul u_mul_q (.a(in_byte), .b(coef.q), .y(term_q));

    logic beat_take;
    logic bad_start;
    gf_t  sum_p, sum_q;

    always_comb begin
        s_d           = s_q;
        s_d.reject    = 1'b0;
        s_d.res_valid = 1'b0;
        s_d.res_last  = 1'b0;

        bad_start = (op_srcs_m1 == '0) || (op_len == '0) || (op_len > LEN_LIMIT);
        if (!s_q.busy && op_start) begin
            if (bad_start) begin
                s_d.reject = 1'b1;
            end else begin
                s_d.busy      = 1'b1;
                s_d.data_last = IDX_W'(op_srcs_m1);
                s_d.beat_last = IDX_W'(op_srcs_m1) + (op_cont ? CONT_EXTRA : '0);
                s_d.pos_left  = op_len;
            end
        end

        beat_take = s_q.busy && in_valid && (in_idx <= s_q.beat_last);
        sum_p = ((in_idx == '0) ? 8'h00 : s_q.acc_p) ^ term_p;
        sum_q = ((in_idx == '0) ? 8'h00 : s_q.acc_q) ^ term_q;

        if (beat_take) begin
            s_d.acc_p = sum_p;
            s_d.acc_q = sum_q;
            if (in_idx == s_q.beat_last) begin
                s_d.res_valid = 1'b1;
                s_d.res_p     = sum_p;
                s_d.res_q     = sum_q;
                s_d.pos_left  = s_q.pos_left - 1'b1;
                if (s_q.pos_left == LEN_W'(1)) begin
                    s_d.busy     = 1'b0;
                    s_d.res_last = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign op_busy   = s_q.busy;
    assign op_reject = s_q.reject;
    assign out_valid = s_q.res_valid;
    assign out_p     = s_q.res_p;
    assign out_q     = s_q.res_q;
    assign out_last  = s_q.res_last;

endmodule

// File: rtl/pq_parity_acc_chk.sv
module pq_parity_acc_chk (
    input logic clk,
    input logic rst_n,
    input logic op_busy,
    input logic op_reject,
    input logic out_valid,
    input logic out_last
);

    // At least two beats per position, so results never come back to back (R5)
    p_result_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // A refused start leaves the block idle (R9)
    p_reject_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_reject |-> !op_busy);

    // A result only comes out of a running operation (R6)
    p_result_in_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(op_busy));

    // The final flag comes with a result and ends the operation (R10)
    p_last_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && !op_busy));

    // Busy only drops on the final result (R10)
    p_busy_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(op_busy) |-> out_last);

endmodule

bind pq_parity_acc pq_parity_acc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_busy   (op_busy),
    .op_reject (op_reject),
    .out_valid (out_valid),
    .out_last  (out_last)
);

// File: tb/pq_parity_acc_tb.sv
`timescale 1ns/1ps
module pq_parity_acc_tb;

    localparam int MAX_LEN = 1048576;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_slot = '0;
    logic [7:0]  cfg_pcoef = '0, cfg_qcoef = '0;
    logic        op_start = 1'b0;
    logic [3:0]  op_srcs_m1 = '0;
    logic        op_cont = 1'b0;
    logic [20:0] op_len = '0;
    logic        op_busy, op_reject;
    logic        in_valid = 1'b0;
    logic [4:0]  in_idx = '0;
    logic [7:0]  in_byte = '0;
    logic        out_valid, out_last;
    logic [7:0]  out_p, out_q;

    always #2 clk = ~clk;

    pq_parity_acc u_dut (.*);

    typedef struct packed { logic [7:0] p; logic [7:0] q; logic last; } exp_t;
    exp_t  sb [$];
    string sb_tag [$];

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] pc_m [16];
    logic [7:0] qc_m [16];
    logic [7:0] src_b [16];

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            r = {r[6:0], 1'b0} ^ (r[7] ? 8'h1D : 8'h00);
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            pc_m[i] = 8'h01;
            qc_m[i] = 8'h01;
        end
    endtask

    task automatic cfg_write(input int slot, input logic [7:0] p, input logic [7:0] q);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = 4'(slot); cfg_pcoef = p; cfg_qcoef = q;
        @(negedge clk);
        cfg_we = 1'b0;
        pc_m[slot] = p;
        qc_m[slot] = q;
    endtask

    task automatic start_op(input int m1, input bit cont, input logic [20:0] len,
                            output bit rej, output bit busy);
        @(negedge clk);
        op_start = 1'b1; op_srcs_m1 = 4'(m1); op_cont = cont; op_len = len;
        @(negedge clk);
        rej = op_reject;
        busy = op_busy;
        op_start = 1'b0;
    endtask

    task automatic beat(input int idx, input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_idx = 5'(idx); in_byte = b;
    endtask

    // One position: n data beats from src_b, then optional fold-back beats
    task automatic run_pos(input int n, input bit cont, input logic [7:0] oldp,
                           input logic [7:0] oldq, input bit last, input int junk_idx,
                           input string tag);
        exp_t e;
        int total;
        e.p = 8'h00; e.q = 8'h00; e.last = last;
        for (int i = 0; i < n; i++) begin
            e.p ^= gmul(pc_m[i], src_b[i]);
            e.q ^= gmul(qc_m[i], src_b[i]);
        end
        if (cont) begin
            e.p ^= gmul(8'h01, oldp) ^ gmul(8'h01, oldq) ^ gmul(8'h01, oldq);
            e.q ^= gmul(8'h00, oldp) ^ gmul(8'h00, oldq) ^ gmul(8'h01, oldq);
        end
        sb.push_back(e);
        sb_tag.push_back(tag);
        total = n + (cont ? 3 : 0);
        for (int k = 0; k < total; k++) begin
            beat(k, (k < n) ? src_b[k] : ((k == n) ? oldp : oldq));
            if (k == 0 && junk_idx >= 0) beat(junk_idx, 8'hEE);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1, {tag, " R6 result one cycle after last beat"}, 32'(out_valid), 1);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R6 unexpected result", {16'h0, out_p, out_q}, 0);
            end else begin
                exp_t e;
                string t;
                e = sb.pop_front();
                t = sb_tag.pop_front();
                chk(out_p === e.p, {t, " R1 P byte"}, 32'(out_p), 32'(e.p));
                chk(out_q === e.q, {t, " R2 Q byte"}, 32'(out_q), 32'(e.q));
                chk(out_last === e.last, {t, " R10 last flag"}, 32'(out_last), 32'(e.last));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 0, 1);
            summary();
        end
    end

    initial begin
        bit rej, busy;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(op_busy === 1'b0, "R11 busy after reset", 32'(op_busy), 0);
        chk(op_reject === 1'b0, "R11 reject after reset", 32'(op_reject), 0);
        chk(out_valid === 1'b0, "R11 valid after reset", 32'(out_valid), 0);
        chk({out_p, out_q, out_last} === 17'h0, "R11 outputs after reset", {out_p, out_q}, 0);

        // R11 default coefficients: two sources, both P and Q plain XOR
        start_op(1, 0, 21'd1, rej, busy);
        chk(busy === 1'b1 && rej === 1'b0, "R10 accepted start raises busy", 32'(busy), 1);
        src_b[0] = 8'hA5; src_b[1] = 8'h3C;
        run_pos(2, 0, 0, 0, 1, -1, "R11 default coefs");
        chk(out_q === 8'h99, "R11 default Q is XOR", 32'(out_q), 32'h99);
        chk(op_busy === 1'b0, "R10 busy falls on final result", 32'(op_busy), 0);

        // R12 program all slots; slot 5 has a non-unity P weight (R1)
        for (int i = 0; i < 16; i++)
            cfg_write(i, (i == 5) ? 8'h03 : 8'h01, (i == 0) ? 8'h02 : 8'(i * 37 + 5));

        // R2 / R3: sixteen sources over three positions
        start_op(15, 0, 21'd3, rej, busy);
        for (int i = 0; i < 16; i++) src_b[i] = 8'h00;
        src_b[0] = 8'h80;
        run_pos(16, 0, 0, 0, 0, -1, "R2 reduction");
        chk(out_q === 8'h1D, "R2 0x80 times 0x02", 32'(out_q), 32'h1D);
        for (int pos = 1; pos < 3; pos++) begin
            for (int i = 0; i < 16; i++) src_b[i] = 8'(i * 29 + pos * 53 + 7);
            run_pos(16, 0, 0, 0, pos == 2, -1, "R3 sixteen sources");
        end

        // R3 count-minus-one: three sources complete on index 2
        start_op(2, 0, 21'd1, rej, busy);
        src_b[0] = 8'h11; src_b[1] = 8'h5E; src_b[2] = 8'hC7;
        run_pos(3, 0, 0, 0, 1, -1, "R3 three sources");

        // R4 continuation: slots 3..5 hold junk that must not be used
        start_op(2, 1, 21'd2, rej, busy);
        src_b[0] = 8'h9B; src_b[1] = 8'h04; src_b[2] = 8'h71;
        run_pos(3, 1, 8'h5A, 8'hC3, 0, -1, "R4 continuation");
        src_b[0] = 8'hFF; src_b[1] = 8'h80; src_b[2] = 8'h2D;
        run_pos(3, 1, 8'h00, 8'h8E, 1, -1, "R4 continuation");

        // R5 single source refused; emulate with duplicate source, weight 0
        start_op(0, 0, 21'd1, rej, busy);
        chk(rej === 1'b1, "R5 single source rejected", 32'(rej), 1);
        chk(busy === 1'b0, "R5 refused start stays idle", 32'(busy), 0);
        cfg_write(0, 8'h01, 8'h1B);
        cfg_write(1, 8'h01, 8'h00);
        start_op(1, 0, 21'd1, rej, busy);
        src_b[0] = 8'h47; src_b[1] = 8'h47;
        run_pos(2, 0, 0, 0, 1, -1, "R5 duplicate source");
        chk(out_p === 8'h00, "R5 duplicated P cancels", 32'(out_p), 0);
        chk(out_q === gmul(8'h1B, 8'h47), "R5 single-source Q", 32'(out_q), 32'(gmul(8'h1B, 8'h47)));

        // R6 result holds after the pulse
        @(negedge clk);
        chk(out_valid === 1'b0, "R6 single-cycle pulse", 32'(out_valid), 0);
        chk(out_q === gmul(8'h1B, 8'h47), "R6 result holds", 32'(out_q), 32'(gmul(8'h1B, 8'h47)));

        // R8 beat while idle is ignored
        beat(1, 8'h77);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b0, "R8 idle beat ignored", 32'(out_valid), 0);

        // R7 stray index-0 beat before restart; R8 out-of-range beat mid-position
        cfg_write(1, 8'h01, 8'h40);
        start_op(1, 0, 21'd2, rej, busy);
        beat(0, 8'hD2);
        src_b[0] = 8'h00; src_b[1] = 8'h01;
        run_pos(2, 0, 0, 0, 0, -1, "R7 restart at index 0");
        chk(out_q === 8'h40, "R12 slot write takes effect", 32'(out_q), 32'h40);
        src_b[0] = 8'h36; src_b[1] = 8'hA9;
        run_pos(2, 0, 0, 0, 1, 2, "R8 out-of-range index");

        // R10 start ignored while busy
        start_op(1, 0, 21'd2, rej, busy);
        start_op(3, 0, 21'd1, rej, busy);
        chk(rej === 1'b0 && busy === 1'b1, "R10 start ignored while busy", {rej, busy}, 1);
        src_b[0] = 8'h12; src_b[1] = 8'h34;
        run_pos(2, 0, 0, 0, 0, -1, "R10 start while busy");
        chk(op_busy === 1'b1, "R10 busy between positions", 32'(op_busy), 1);
        src_b[0] = 8'h56; src_b[1] = 8'h78;
        run_pos(2, 0, 0, 0, 1, -1, "R10 start while busy");

        // R9 length limits
        start_op(1, 0, 21'd0, rej, busy);
        chk(rej === 1'b1 && busy === 1'b0, "R9 zero length refused", {rej, busy}, 2);
        start_op(1, 0, 21'(MAX_LEN + 1), rej, busy);
        chk(rej === 1'b1 && busy === 1'b0, "R9 over-limit refused", {rej, busy}, 2);
        start_op(1, 0, 21'(MAX_LEN), rej, busy);
        chk(rej === 1'b0 && busy === 1'b1, "R9 exact limit accepted", {rej, busy}, 1);

        // R11 reset aborts and restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        chk(op_busy === 1'b0, "R11 reset clears busy", 32'(op_busy), 0);
        start_op(1, 0, 21'd1, rej, busy);
        src_b[0] = 8'h0F; src_b[1] = 8'hF1;
        run_pos(2, 0, 0, 0, 1, -1, "R11 coefs after reset");

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R6 all expected results seen", sb.size(), 0);
        finished = 1'b1;
        summary();
    end

endmodule